// File: doc/BRIEF.md
# Update-Protocol Snooping Coherence Controller

This block keeps one processor's small direct-mapped write-back cache coherent with its peers on a shared bus. It uses an update protocol. Each cache line holds one data word. A line that is present is always valid and carries one of four states:

- exclusive-clean;
- shared-clean;
- shared-modified, where this cache owns the block and memory is stale;
- modified, where this cache holds the only dirty copy.

When the processor writes to a shared block, the controller does not invalidate the other copies. It broadcasts the written word so that the peers can refresh their own copies. Ownership of dirty shared data moves to whichever cache wrote last.

On the processor side, the controller accepts one read or write at a time and answers with a single-cycle done pulse. On the bus side, it issues reads, single-word updates and write-backs. Each request is held until the bus grants and completes it. At that point the controller samples the returned data and a wired shared indication. The controller also watches the bus reads and updates issued by other caches. It raises the shared output when it holds the block and supplies the data when it owns a dirty copy.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset, no bus request and no done pulse are raised, and no snooped address is reported as shared.
- R2: A read miss issues a bus read (bus_cmd 2'b01). On completion the returned word goes to the processor. The line is filled as exclusive-clean if bus_shared_in was low at the grant, and as shared-clean if it was high.
- R3: A write miss issues a bus read. If shared was sampled high, a bus update (bus_cmd 2'b10) carrying the written word follows, and the line becomes shared-modified. If shared was sampled low, no further bus transaction occurs and the line becomes modified.
- R4: A write hit to an exclusive-clean or modified line completes with no bus transaction and leaves the line modified.
- R5: A write hit to a shared-clean or shared-modified line broadcasts a bus update carrying the written word. The line ends shared-modified if shared was sampled high at the grant, and modified if it was low.
- R6: A snooped update (snp_is_upd = 1) to a held block stores the broadcast word in the local copy. Any held state then becomes shared-clean, so a later snooped read sees the block shared but not flushed.
- R7: A snooped read (snp_is_upd = 0) to a held block raises snp_shared. The resulting state depends on the state the line held:
  - modified: the line flushes its word on snp_data and becomes shared-modified;
  - shared-modified: the line flushes and stays shared-modified;
  - exclusive-clean: the line becomes shared-clean;
  - shared-clean: the line stays shared-clean and does not flush.
- R8: A miss that displaces a shared-modified or modified line first issues a write-back (bus_cmd 2'b11) with the victim's address and word, and then the bus read. Displacing a clean line issues no write-back.
- R9: When a snoop and a processor request target the same set in the same cycle, the snoop takes effect first. The processor request is served afterwards, on the line state the snoop left.
- R10: cpu_done is a one-cycle pulse. While bus_req is high and bus_gnt is low, the command, address and data on the bus stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Word address (tag high, set index low) |
| cpu_wdata | input | DW | Write word |
| cpu_rdata | output | DW | Read word, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 01 read, 10 update, 11 write-back |
| bus_addr | output | TAG_W+IDX_W | Transaction address |
| bus_wdata | output | DW | Word for an update or write-back |
| bus_gnt | input | 1 | One-cycle completion of the requested transaction |
| bus_rdata | input | DW | Read data, valid with bus_gnt |
| bus_shared_in | input | 1 | Wired shared indication, sampled with bus_gnt |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_is_upd | input | 1 | 1 = peer update, 0 = peer read |
| snp_addr | input | TAG_W+IDX_W | Peer transaction address |
| snp_wdata | input | DW | Peer update word |
| snp_shared | output | 1 | This cache holds the snooped block |
| snp_flush | output | 1 | This cache supplies the block on a snooped read |
| snp_data | output | DW | Supplied word |

## Verification
A snoop and a processor access can arrive in the same cycle. The processor side may write the line directly on a hit, while the snoop side changes the state of the same line. The bench provokes this collision on purpose: it presents a peer read together with a processor write to a modified line at the same set. The result is judged at the ports. The snoop must flush the old word. The processor write must then appear as a bus update, because the line is now shared-modified. The bench also issues same-cycle pairs on different sets, and random runs inject such pairs, each checked against the reference model in the bench.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_EXCL  = 2'd0,
    LS_SHCLN = 2'd1,
    LS_SHMOD = 2'd2,
    LS_MOD   = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_READ = 2'd1,
    BC_UPD  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_t;

  function automatic logic st_dirty(line_st_t s);
    return (s == LS_SHMOD) || (s == LS_MOD);
  endfunction
endpackage

// File: rtl/coh_snoop_rule.sv
module coh_snoop_rule
  import coh_pkg::*;
(
  input  line_st_t cur_st,
  input  logic     is_upd,
  output line_st_t nxt_st,
  output logic     flush
);
  always_comb begin
    flush  = 1'b0;
    nxt_st = cur_st;
    if (is_upd) begin
      nxt_st = LS_SHCLN;
    end else begin
      flush = st_dirty(cur_st);
      case (cur_st)
        LS_MOD:  nxt_st = LS_SHMOD;
        LS_EXCL: nxt_st = LS_SHCLN;
        default: nxt_st = cur_st;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [DW-1:0]    rd_data,
  output line_st_t         rd_st,
  input  logic             snp_valid,
  input  logic             snp_is_upd,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [DW-1:0]    snp_wdata,
  output logic             snp_hit,
  output logic             snp_dirty,
  output logic [DW-1:0]    snp_data,
  input  logic             fw_en,
  input  logic [IDX_W-1:0] fw_idx,
  input  logic             fw_valid,
  input  logic [TAG_W-1:0] fw_tag,
  input  logic [DW-1:0]    fw_data,
  input  line_st_t         fw_st
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [DW-1:0]    data_q [SETS];
  line_st_t         st_q   [SETS];
  line_st_t         snp_nst;
  logic             flush_need;
  logic             snp_we;

  coh_snoop_rule u_rule (
    .cur_st (st_q[snp_idx]),
    .is_upd (snp_is_upd),
    .nxt_st (snp_nst),
    .flush  (flush_need)
  );

  assign rd_valid  = vld_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_data   = data_q[rd_idx];
  assign rd_st     = st_q[rd_idx];
  assign snp_hit   = vld_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign snp_dirty = snp_hit && flush_need;
  assign snp_data  = data_q[snp_idx];
  assign snp_we    = snp_valid && snp_hit;

  always_comb begin
    vld_d = vld_q;
    if (fw_en) vld_d[fw_idx] = fw_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (snp_we) begin
      st_q[snp_idx] <= snp_nst;
      if (snp_is_upd) data_q[snp_idx] <= snp_wdata;
    end
    if (fw_en) begin
      tag_q[fw_idx]  <= fw_tag;
      data_q[fw_idx] <= fw_data;
      st_q[fw_idx]   <= fw_st;
    end
  end
endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
  import coh_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4,
  parameter int DW    = 32,
  localparam int AW   = TAG_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_done,
  output logic             bus_req,
  output logic [1:0]       bus_cmd,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_gnt,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_shared_in,
  input  logic             snp_valid,
  input  logic [IDX_W-1:0] snp_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [DW-1:0]    rd_data,
  input  line_st_t         rd_st,
  output logic             fw_en,
  output logic [IDX_W-1:0] fw_idx,
  output logic             fw_valid,
  output logic [TAG_W-1:0] fw_tag,
  output logic [DW-1:0]    fw_data,
  output line_st_t         fw_st
);
  typedef enum logic [2:0] {ST_IDLE, ST_WB, ST_FILL, ST_UPD, ST_RESP} fsm_t;

  fsm_t          state, nstate;
  logic [AW-1:0] req_addr;
  logic          req_we;
  logic [DW-1:0] req_wdata, rdata_q, rdata_nx;
  logic          acc, rdata_ld, collide, cpu_hit;
  bus_cmd_t      cmd;

  wire [IDX_W-1:0] cpu_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] cpu_tag = cpu_addr[AW-1:IDX_W];
  wire [IDX_W-1:0] req_idx = req_addr[IDX_W-1:0];
  wire [TAG_W-1:0] req_tag = req_addr[AW-1:IDX_W];

  assign rd_idx    = (state == ST_IDLE) ? cpu_idx : req_idx;
  assign collide   = snp_valid && (snp_idx == cpu_idx);
  assign cpu_hit   = rd_valid && (rd_tag == cpu_tag);
  assign cpu_done  = (state == ST_RESP);
  assign cpu_rdata = rdata_q;
  assign bus_cmd   = cmd;

  always_comb begin
    nstate    = state;
    acc       = 1'b0;
    rdata_ld  = 1'b0;
    rdata_nx  = rd_data;
    fw_en     = 1'b0;
    fw_idx    = req_idx;
    fw_valid  = 1'b1;
    fw_tag    = req_tag;
    fw_data   = req_wdata;
    fw_st     = LS_MOD;
    bus_req   = 1'b0;
    cmd       = BC_NONE;
    bus_addr  = req_addr;
    bus_wdata = req_wdata;
    case (state)
      ST_IDLE: if (cpu_req && !collide) begin
        acc = 1'b1;
        if (cpu_hit && !cpu_we) begin
          rdata_ld = 1'b1;
          nstate   = ST_RESP;
        end else if (cpu_hit && !st_dirty(rd_st) && rd_st != LS_EXCL) begin
          nstate = ST_UPD;
        end else if (cpu_hit && rd_st == LS_SHMOD) begin
          nstate = ST_UPD;
        end else if (cpu_hit) begin
          fw_en   = 1'b1;
          fw_idx  = cpu_idx;
          fw_tag  = cpu_tag;
          fw_data = cpu_wdata;
          nstate  = ST_RESP;
        end else begin
          nstate = (rd_valid && st_dirty(rd_st)) ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        if (!(rd_valid && st_dirty(rd_st))) begin
          nstate = ST_FILL;
        end else begin
          bus_req   = 1'b1;
          cmd       = BC_WB;
          bus_addr  = {rd_tag, req_idx};
          bus_wdata = rd_data;
          if (bus_gnt) begin
            fw_en    = 1'b1;
            fw_valid = 1'b0;
            fw_tag   = rd_tag;
            fw_data  = rd_data;
            fw_st    = rd_st;
            nstate   = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        bus_req = 1'b1;
        cmd     = BC_READ;
        if (bus_gnt) begin
          fw_en = 1'b1;
          if (!req_we) begin
            fw_data  = bus_rdata;
            fw_st    = bus_shared_in ? LS_SHCLN : LS_EXCL;
            rdata_ld = 1'b1;
            rdata_nx = bus_rdata;
            nstate   = ST_RESP;
          end else if (bus_shared_in) begin
            fw_data = bus_rdata;
            fw_st   = LS_SHCLN;
            nstate  = ST_UPD;
          end else begin
            nstate = ST_RESP;
          end
        end
      end
      ST_UPD: begin
        bus_req = 1'b1;
        cmd     = BC_UPD;
        if (bus_gnt) begin
          fw_en  = 1'b1;
          fw_st  = bus_shared_in ? LS_SHMOD : LS_MOD;
          nstate = ST_RESP;
        end
      end
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nstate;
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      req_addr  <= cpu_addr;
      req_we    <= cpu_we;
      req_wdata <= cpu_wdata;
    end
    if (rdata_ld) rdata_q <= rdata_nx;
  end
endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4,
  parameter int DW    = 32,
  localparam int AW   = TAG_W + IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_done,
  output logic          bus_req,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic          snp_is_upd,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_wdata,
  output logic          snp_shared,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data
);
  logic [IDX_W-1:0] rd_idx, fw_idx;
  logic             rd_valid, fw_en, fw_valid, snp_hit, snp_dirty;
  logic [TAG_W-1:0] rd_tag, fw_tag;
  logic [DW-1:0]    rd_data, fw_data;
  line_st_t         rd_st, fw_st;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .rd_data    (rd_data),
    .rd_st      (rd_st),
    .snp_valid  (snp_valid),
    .snp_is_upd (snp_is_upd),
    .snp_idx    (snp_addr[IDX_W-1:0]),
    .snp_tag    (snp_addr[AW-1:IDX_W]),
    .snp_wdata  (snp_wdata),
    .snp_hit    (snp_hit),
    .snp_dirty  (snp_dirty),
    .snp_data   (snp_data),
    .fw_en      (fw_en),
    .fw_idx     (fw_idx),
    .fw_valid   (fw_valid),
    .fw_tag     (fw_tag),
    .fw_data    (fw_data),
    .fw_st      (fw_st)
  );

  coh_ctrl_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_gnt       (bus_gnt),
    .bus_rdata     (bus_rdata),
    .bus_shared_in (bus_shared_in),
    .snp_valid     (snp_valid),
    .snp_idx       (snp_addr[IDX_W-1:0]),
    .rd_idx        (rd_idx),
    .rd_valid      (rd_valid),
    .rd_tag        (rd_tag),
    .rd_data       (rd_data),
    .rd_st         (rd_st),
    .fw_en         (fw_en),
    .fw_idx        (fw_idx),
    .fw_valid      (fw_valid),
    .fw_tag        (fw_tag),
    .fw_data       (fw_data),
    .fw_st         (fw_st)
  );

  assign snp_shared = snp_valid && snp_hit;
  assign snp_flush  = snp_valid && !snp_is_upd && snp_dirty;
endmodule

// File: rtl/upd_coh_ctrl_chk.sv
module upd_coh_ctrl_chk #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 4,
  parameter int DW    = 32,
  localparam int AW   = TAG_W + IDX_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          cpu_done,
  input logic          bus_req,
  input logic [1:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_gnt,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_shared_in,
  input logic          snp_valid,
  input logic          snp_is_upd,
  input logic [AW-1:0] snp_addr,
  input logic [DW-1:0] snp_wdata,
  input logic          snp_shared,
  input logic          snp_flush,
  input logic [DW-1:0] snp_data
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_wdata)));

  // R10
  bus_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_cmd != 2'b00));

  // R7
  flush_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_shared);

  // R7
  own_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_is_upd && $past(snp_valid && !snp_is_upd && snp_flush)
     && (snp_addr == $past(snp_addr)) && !$past(bus_gnt)) |-> snp_flush);

  // R6
  own_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_is_upd && $past(snp_valid && snp_is_upd && snp_shared)
     && (snp_addr == $past(snp_addr)) && !$past(bus_gnt)) |-> (snp_shared && !snp_flush));
endmodule

bind upd_coh_ctrl upd_coh_ctrl_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_chk (.*);

// File: tb/upd_coh_ctrl_test.sv
`timescale 1ns/1ps
module upd_coh_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [7:0]  cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_done;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_gnt, bus_shared_in;
  logic        snp_valid, snp_is_upd;
  logic [7:0]  snp_addr;
  logic [31:0] snp_wdata, snp_data;
  logic        snp_shared, snp_flush;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  // reference model; state codes 0 excl, 1 shared-clean, 2 shared-mod, 3 mod
  logic        rv   [16];
  logic [3:0]  rtag [16];
  logic [31:0] rdat [16];
  int          rst  [16];
  logic [31:0] mem  [256];

  always #4 clk = ~clk;

  upd_coh_ctrl uut (.*);

  function automatic logic [31:0] mem_init(int i);
    return {16'hC0DE, 8'(i), 8'(~i)};
  endfunction

  function automatic logic pick_sh(int m);
    if (m == 2) return 1'($urandom % 2);
    return (m == 1);
  endfunction

  function automatic logic ref_dirty(int s);
    return (s == 2) || (s == 3);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_snoop(input logic upd, input logic [7:0] a, input logic [31:0] d,
                           output logic hit, output logic fl, output logic [31:0] fd);
    int ix;
    ix  = int'(a[3:0]);
    hit = rv[ix] && rtag[ix] == a[7:4];
    fl  = 1'b0;
    fd  = rdat[ix];
    if (hit) begin
      if (upd) begin
        rdat[ix] = d;
        rst[ix]  = 1;
      end else begin
        fl = ref_dirty(rst[ix]);
        if (rst[ix] == 3) rst[ix] = 2;
        else if (rst[ix] == 0) rst[ix] = 1;
      end
    end
  endtask

  task automatic snoop_chk(input logic hit, input logic fl, input logic [31:0] fd, input string tag);
    check(snp_shared == hit, {tag, " snoop shared"}, 32'(snp_shared), 32'(hit));
    check(snp_flush == fl, {tag, " snoop flush"}, 32'(snp_flush), 32'(fl));
    if (fl) check(snp_data == fd, {tag, " flush data"}, snp_data, fd);
  endtask

  task automatic snoop_only(input logic upd, input logic [7:0] a, input logic [31:0] d, input string tag);
    logic hit, fl;
    logic [31:0] fd;
    ref_snoop(upd, a, d, hit, fl, fd);
    snp_valid = 1'b1; snp_is_upd = upd; snp_addr = a; snp_wdata = d;
    #1;
    snoop_chk(hit, fl, fd, tag);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [31:0] w, input int shm,
                        input logic sn_en, input logic sn_upd, input logic [7:0] sa,
                        input logic [31:0] sd, input string tag);
    logic [1:0]  ecmd [3];
    logic [7:0]  eaddr[3];
    logic [31:0] edat [3];
    logic        esh  [3];
    int n, k, ix, dly, wd;
    logic hit, shit, sfl, granted;
    logic [31:0] sfd, exp_rd, mv;
    n = 0; k = 0; exp_rd = '0; granted = 1'b0; wd = 0;
    shit = 1'b0; sfl = 1'b0; sfd = '0;
    if (sn_en) ref_snoop(sn_upd, sa, sd, shit, sfl, sfd);
    ix  = int'(a[3:0]);
    hit = rv[ix] && rtag[ix] == a[7:4];
    if (hit) begin
      if (!we) exp_rd = rdat[ix];
      else if (rst[ix] == 0 || rst[ix] == 3) begin rst[ix] = 3; rdat[ix] = w; end
      else begin
        ecmd[n] = 2'b10; eaddr[n] = a; edat[n] = w; esh[n] = pick_sh(shm); n++;
        rst[ix] = esh[n-1] ? 2 : 3; rdat[ix] = w;
      end
    end else begin
      if (rv[ix] && ref_dirty(rst[ix])) begin
        ecmd[n] = 2'b11; eaddr[n] = {rtag[ix], a[3:0]}; edat[n] = rdat[ix]; esh[n] = 1'b0; n++;
      end
      ecmd[n] = 2'b01; eaddr[n] = a; edat[n] = '0; esh[n] = pick_sh(shm); n++;
      mv = mem[a];
      rv[ix] = 1'b1; rtag[ix] = a[7:4];
      if (!we) begin rst[ix] = esh[n-1] ? 1 : 0; rdat[ix] = mv; exp_rd = mv; end
      else if (esh[n-1]) begin
        ecmd[n] = 2'b10; eaddr[n] = a; edat[n] = w; esh[n] = pick_sh(shm); n++;
        rst[ix] = esh[n-1] ? 2 : 3; rdat[ix] = w;
      end else begin rst[ix] = 3; rdat[ix] = w; end
    end
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = w;
    if (sn_en) begin
      snp_valid = 1'b1; snp_is_upd = sn_upd; snp_addr = sa; snp_wdata = sd;
      #1;
      snoop_chk(shit, sfl, sfd, {tag, " same-cycle R9"});
    end
    dly = int'($urandom % 2);
    forever begin
      @(negedge clk);
      snp_valid = 1'b0;
      if (granted) begin bus_gnt = 1'b0; granted = 1'b0; end
      wd++;
      if (cpu_done) break;
      if (wd > 60) begin check(1'b0, {tag, " op hung"}, 32'(wd), 32'd60); break; end
      if (bus_req) begin
        if (k >= n) begin
          check(1'b0, {tag, " unexpected bus cmd"}, 32'(bus_cmd), 32'd0);
          break;
        end else if (dly > 0) dly--;
        else begin
          check(bus_cmd == ecmd[k], {tag, " bus cmd"}, 32'(bus_cmd), 32'(ecmd[k]));
          check(bus_addr == eaddr[k], {tag, " bus addr"}, 32'(bus_addr), 32'(eaddr[k]));
          if (ecmd[k] != 2'b01)
            check(bus_wdata == edat[k], {tag, " bus word"}, bus_wdata, edat[k]);
          if (bus_cmd == 2'b11) mem[bus_addr] = bus_wdata;
          bus_rdata = mem[bus_addr]; bus_shared_in = esh[k];
          bus_gnt = 1'b1; granted = 1'b1; k++;
          dly = int'($urandom % 2);
        end
      end
    end
    check(k == n, {tag, " bus transaction count"}, 32'(k), 32'(n));
    if (!we) check(cpu_rdata == exp_rd, {tag, " read word"}, cpu_rdata, exp_rd);
    cpu_req = 1'b0;
    bus_gnt = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
    for (int i = 0; i < 16; i++) begin rv[i] = 1'b0; rtag[i] = '0; rdat[i] = '0; rst[i] = 0; end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 1'b0; bus_rdata = '0; bus_shared_in = 1'b0;
    snp_valid = 1'b0; snp_is_upd = 1'b0; snp_addr = '0; snp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!cpu_done, "R1 done after reset", 32'(cpu_done), 32'd0);
    check(!bus_req, "R1 bus idle after reset", 32'(bus_req), 32'd0);
    snoop_only(1'b0, 8'h00, '0, "R1");
    // R2 read miss, not shared -> exclusive
    cpu_op(1'b0, 8'h03, '0, 0, 1'b0, 1'b0, '0, '0, "R2");
    // R4 write hit exclusive -> modified, no bus
    cpu_op(1'b1, 8'h03, 32'h1111_0003, 0, 1'b0, 1'b0, '0, '0, "R4");
    // R7 modified flushes -> shared-modified, flushes again
    snoop_only(1'b0, 8'h03, '0, "R7 mod");
    snoop_only(1'b0, 8'h03, '0, "R7 shmod");
    // R6 peer update takes ownership
    snoop_only(1'b1, 8'h03, 32'hBEEF_0003, "R6 upd");
    snoop_only(1'b0, 8'h03, '0, "R6 after");
    cpu_op(1'b0, 8'h03, '0, 0, 1'b0, 1'b0, '0, '0, "R6 read");
    // R5 write hit shared
    cpu_op(1'b1, 8'h03, 32'h2222_0003, 1, 1'b0, 1'b0, '0, '0, "R5 shared");
    cpu_op(1'b1, 8'h03, 32'h3333_0003, 0, 1'b0, 1'b0, '0, '0, "R5 alone");
    cpu_op(1'b1, 8'h03, 32'h4444_0003, 0, 1'b0, 1'b0, '0, '0, "R4 mod");
    // R8 dirty eviction then clean eviction
    cpu_op(1'b0, 8'h13, '0, 0, 1'b0, 1'b0, '0, '0, "R8 dirty");
    cpu_op(1'b0, 8'h23, '0, 1, 1'b0, 1'b0, '0, '0, "R8 clean");
    snoop_only(1'b0, 8'h23, '0, "R2 shared fill");
    // R3 write misses
    cpu_op(1'b1, 8'h05, 32'h5555_0005, 1, 1'b0, 1'b0, '0, '0, "R3 shared");
    snoop_only(1'b0, 8'h05, '0, "R3 owner");
    cpu_op(1'b1, 8'h06, 32'h6666_0006, 0, 1'b0, 1'b0, '0, '0, "R3 alone");
    // R7 exclusive snooped -> shared-clean, then a write needs an update
    cpu_op(1'b0, 8'h07, '0, 0, 1'b0, 1'b0, '0, '0, "R2 excl");
    snoop_only(1'b0, 8'h07, '0, "R7 excl");
    cpu_op(1'b1, 8'h07, 32'h7777_0007, 0, 1'b0, 1'b0, '0, '0, "R7 excl write");
    // R9 same-cycle snoop and processor access
    cpu_op(1'b1, 8'h06, 32'h6767_0006, 1, 1'b1, 1'b0, 8'h06, '0, "R9 same set");
    cpu_op(1'b0, 8'h05, '0, 0, 1'b1, 1'b0, 8'h07, '0, "R9 other set");
    // random mix
    for (int it = 0; it < 300; it++) begin
      logic [7:0] ra, sa;
      logic supd, sen;
      int sx;
      ra = {2'b00, 2'($urandom % 3), 2'b00, 2'($urandom % 4)};
      sa = {2'b00, 2'($urandom % 3), 2'b00, 2'($urandom % 4)};
      sx = int'(sa[3:0]);
      supd = 1'($urandom % 2);
      if (supd && rv[sx] && rtag[sx] == sa[7:4] && (rst[sx] == 0 || rst[sx] == 3)) supd = 1'b0;
      sen = ($urandom % 4) == 0;
      if (($urandom % 5) == 0) snoop_only(supd, sa, $urandom, "R7 rand snoop");
      else cpu_op(1'($urandom % 2), ra, $urandom, 2, sen, supd, sa, $urandom, "R5 rand op");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule